// File: doc/BRIEF.md
# Two-Source Binary Tree Destination Router

This block is a circuit-switched fabric that joins two requesting sources to eight destination ports. The fabric is a tree of 2x2 interchange cells: one cell at the root and, for the default depth of three levels, two cells below it and four at the leaves. A source raises its request with a destination number and a data word. The destination number alone steers the path. Its most significant bit sets the root cell, the next bit sets the second level and the least significant bit sets the leaf level. A 0 bit takes the upper (lower-numbered) output and a 1 bit takes the lower (higher-numbered) output, so destination 101 leaves the root on output 1, the middle cell on output 0 and the leaf cell on output 1.

Both sources enter the same root cell, so only the top destination bit can collide. Once one source owns a path into one half of the destination ports, the other source can only reach the other half. A clock edge samples each fresh request. It then either locks the path or returns a one-cycle block pulse. A locked path carries the source's data word straight to its destination port until the source drops its request. Ports with no path show zero data and a low valid.

Top module: `bin_tree_router`

## Requirements
- R1: After reset, and while reset is held, every grant, every block pulse and every destination valid is low, and every destination data word is zero.
- R2: A source that holds a grant for destination d (3-bit binary, bit 2 steering the root) drives destination port d with valid high, and that port's data equals the source's current data word.
- R3: A grant is not visible in the cycle the request is first presented. It appears after the next rising clock edge, provided the requested half is free.
- R4: Either source, when alone, can be granted each of the eight destinations 0 through 7.
- R5: While one source holds a path into a half (destination bit 2 equal to h), a new request from the other source for half h is blocked. A new request for the other half is granted.
- R6: When both sources present fresh requests in the same cycle for the same half, source 0 is granted and source 1 is blocked. Fresh requests for different halves are both granted.
- R7: A path already held by source 1 beats a fresh request from source 0 for the same half.
- R8: A block lasts exactly one cycle. A blocked source gets no grant while it keeps its request high, even after the half becomes free. It must drop the request and raise it again.
- R9: While a path is held, changes to that source's destination input are ignored. Data changes reach the destination port in the same cycle.
- R10: A source releases its path by driving its request low. The grant and the port's valid drop after the next edge. A request from the other source for the same half, presented in the cycle of the release, is still blocked.
- R11: Every destination port with no path outputs zero data and a low valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 2 | Request from each source (bit i = source i) |
| src_dst | input | 2*LEVELS | Destination number per source, source i at [i*LEVELS +: LEVELS] |
| src_data | input | 2*DW | Data word per source, source i at [i*DW +: DW] |
| src_gnt | output | 2 | Path held for each source |
| src_blk | output | 2 | One-cycle block pulse per source |
| dst_vld | output | 2**LEVELS | Valid per destination port |
| dst_data | output | (2**LEVELS)*DW | Data per destination port, port k at [k*DW +: DW] |

## Verification
Grant and block are registered once, so they are due one edge after the request is presented. The bench drives every input at a falling edge and samples at the following falling edge, after exactly one rising edge. Destination valid follows the grant register in the same cycle. Destination data is purely combinational from the source data along a held path, so a data change is checked in the same sampling window as it is applied. The no-grant-yet case of R3 is sampled just after the inputs change and before any rising edge.

// File: rtl/xt_pkg.sv
package xt_pkg;
   localparam int N_SRC = 2;

   // Outcome of one source's request in a given cycle
   typedef enum logic [1:0] {
      VD_IDLE  = 2'd0,
      VD_GRANT = 2'd1,
      VD_BLOCK = 2'd2
   } verdict_e;
endpackage

// File: rtl/xt_swap_cell.sv
module xt_swap_cell #(
   parameter int LEVELS = 3,
   parameter int DW     = 8,
   parameter int SEL    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LEVELS+DW:0]      in_a,
   input  logic [LEVELS+DW:0]      in_b,
   output logic [LEVELS+DW:0]      out_lo,
   output logic [LEVELS+DW:0]      out_hi
);
   localparam int LW    = 1 + LEVELS + DW;
   localparam int V_BIT = LW - 1;
   localparam int S_BIT = DW + SEL;

   if (SEL < 0 || SEL >= LEVELS) begin : g_bad_sel
      $error("xt_swap_cell: SEL out of range");
   end

   logic a_lo, a_hi, b_lo, b_hi;

   always_comb begin
      a_lo = in_a[V_BIT] & ~in_a[S_BIT];
      a_hi = in_a[V_BIT] &  in_a[S_BIT];
      b_lo = in_b[V_BIT] & ~in_b[S_BIT];
      b_hi = in_b[V_BIT] &  in_b[S_BIT];
   end

   // Input A has the fixed edge inside the cell; the root arbiter keeps
   // a collision from ever arriving here.
   always_comb begin
      if (a_lo)      out_lo = in_a;
      else if (b_lo) out_lo = in_b;
      else           out_lo = '0;
      if (a_hi)      out_hi = in_a;
      else if (b_hi) out_hi = in_b;
      else           out_hi = '0;
   end

   AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_lo && b_lo) && !(a_hi && b_hi)); // R6
endmodule

// File: rtl/xt_root_arbiter.sv
module xt_root_arbiter #(
   parameter int LEVELS = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              req,
   input  logic [2*LEVELS-1:0]     dst_in,
   output logic [1:0]              held,
   output logic [2*LEVELS-1:0]     held_dst,
   output logic [1:0]              blk
);
   import xt_pkg::*;

   localparam int TOP = LEVELS - 1;

   logic [1:0] wait_drop;
   logic [1:0] cand;
   logic [1:0] want_half;
   logic [1:0] half_busy;
   logic [1:0] win;
   logic [1:0] lose;
   verdict_e   vd [N_SRC];

   always_comb begin
      half_busy = '0;
      for (int i = 0; i < N_SRC; i++) begin
         want_half[i] = dst_in[i*LEVELS+TOP];
         if (held[i]) half_busy[held_dst[i*LEVELS+TOP]] = 1'b1;
      end
   end

   assign cand = req & ~held & ~wait_drop;

   // Held paths own their half; among fresh requests source 0 comes first.
   always_comb begin
      win[0] = cand[0] & ~half_busy[want_half[0]];
      win[1] = cand[1] & ~half_busy[want_half[1]]
             & ~(win[0] & (want_half[0] == want_half[1]));
      for (int i = 0; i < N_SRC; i++) begin
         if (win[i])       vd[i] = VD_GRANT;
         else if (cand[i]) vd[i] = VD_BLOCK;
         else              vd[i] = VD_IDLE;
         lose[i] = (vd[i] == VD_BLOCK);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= '0;
         held_dst  <= '0;
         wait_drop <= '0;
         blk       <= '0;
      end else begin
         held      <= (held & req) | win;
         wait_drop <= lose | (wait_drop & req);
         blk       <= lose;
         for (int i = 0; i < N_SRC; i++) begin
            if (win[i]) held_dst[i*LEVELS +: LEVELS] <= dst_in[i*LEVELS +: LEVELS];
         end
      end
   end

   AST_HALF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (held == 2'b11) |-> (held_dst[TOP] != held_dst[LEVELS+TOP])); // R5

   for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
      AST_BLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         blk[i] |=> !blk[i]); // R8
      AST_PATH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
         (held[i] && $past(held[i])) |->
            (held_dst[i*LEVELS +: LEVELS] == $past(held_dst[i*LEVELS +: LEVELS]))); // R9
      AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
         (blk[i] && req[i]) |=> !held[i]); // R8
   end
endmodule

// File: rtl/bin_tree_router.sv
module bin_tree_router #(
   parameter int LEVELS = 3,
   parameter int DW     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   src_req,
   input  logic [2*LEVELS-1:0]          src_dst,
   input  logic [2*DW-1:0]              src_data,
   output logic [1:0]                   src_gnt,
   output logic [1:0]                   src_blk,
   output logic [(2**LEVELS)-1:0]       dst_vld,
   output logic [(2**LEVELS)*DW-1:0]    dst_data
);
   import xt_pkg::*;

   localparam int N_DST = 2 ** LEVELS;
   localparam int LW    = 1 + LEVELS + DW;

   if (LEVELS < 1 || LEVELS > 6) begin : g_bad_levels
      $error("bin_tree_router: LEVELS must be 1..6");
   end
   if (DW < 1) begin : g_bad_dw
      $error("bin_tree_router: DW must be at least 1");
   end

   logic [1:0]          held;
   logic [2*LEVELS-1:0] held_dst;
   logic [LW-1:0]       src_link [N_SRC];
   // Heap numbering: node n feeds links 2n and 2n+1; leaf link N_DST+k is port k
   logic [LW-1:0]       link [2:2*N_DST-1];

   xt_root_arbiter #(.LEVELS(LEVELS)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (src_req),
      .dst_in   (src_dst),
      .held     (held),
      .held_dst (held_dst),
      .blk      (src_blk)
   );

   assign src_gnt = held;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign src_link[i] = {held[i], held_dst[i*LEVELS +: LEVELS], src_data[i*DW +: DW]};
   end

   for (genvar n = 1; n < N_DST; n++) begin : g_node
      localparam int DEPTH = $clog2(n + 1) - 1;
      localparam int SEL   = LEVELS - 1 - DEPTH;
      if (n == 1) begin : g_root
         xt_swap_cell #(.LEVELS(LEVELS), .DW(DW), .SEL(SEL)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_a   (src_link[0]),
            .in_b   (src_link[1]),
            .out_lo (link[2]),
            .out_hi (link[3])
         );
      end else begin : g_inner
         xt_swap_cell #(.LEVELS(LEVELS), .DW(DW), .SEL(SEL)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_a   (link[n]),
            .in_b   ({LW{1'b0}}),
            .out_lo (link[2*n]),
            .out_hi (link[2*n+1])
         );
      end
   end

   for (genvar k = 0; k < N_DST; k++) begin : g_port
      assign dst_vld[k]           = link[N_DST+k][LW-1];
      assign dst_data[k*DW +: DW] = link[N_DST+k][DW-1:0];

      AST_LEAF_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
         dst_vld[k] |-> (link[N_DST+k][DW +: LEVELS] == LEVELS'(k))); // R2
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !dst_vld[k] |-> (dst_data[k*DW +: DW] == '0)); // R11
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
      logic [LEVELS-1:0] hd;
      assign hd = held_dst[i*LEVELS +: LEVELS];
      AST_GNT_REACHES: assert property (@(posedge clk) disable iff (!rst_n)
         src_gnt[i] |-> (dst_vld[hd] && dst_data[hd*DW +: DW] == src_data[i*DW +: DW])); // R2
   end

   AST_VLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dst_vld) == $countones(src_gnt)); // R11
endmodule

// File: tb/test_bin_tree_router.sv
module test_bin_tree_router;
   localparam int LEVELS = 3;
   localparam int DW     = 8;
   localparam int ND     = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    src_req = '0;
   logic [5:0]    src_dst = '0;
   logic [15:0]   src_data = '0;
   logic [1:0]    src_gnt, src_blk;
   logic [7:0]    dst_vld;
   logic [63:0]   dst_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bin_tree_router #(.LEVELS(LEVELS), .DW(DW)) i_bin_tree_router (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_dst(src_dst),
      .src_data(src_data), .src_gnt(src_gnt), .src_blk(src_blk),
      .dst_vld(dst_vld), .dst_data(dst_data)
   );

   typedef struct packed {
      logic       r0; logic [2:0] d0; logic [7:0] x0;
      logic       r1; logic [2:0] d1; logic [7:0] x1;
      logic [1:0] eg; logic [1:0] eb; logic [7:0] ev;
   } vec_t;

   localparam vec_t TBL [12] = '{
      '{1'b1,3'd5,8'hA1, 1'b0,3'd0,8'h00, 2'b01,2'b00,8'h20}, // R2 R3 src0 -> 5
      '{1'b1,3'd5,8'hB2, 1'b1,3'd6,8'hC3, 2'b01,2'b10,8'h20}, // R5 same half blocked
      '{1'b1,3'd2,8'hB3, 1'b1,3'd2,8'hC4, 2'b01,2'b00,8'h20}, // R8 R9 no regrant, dst ignored
      '{1'b1,3'd5,8'hB4, 1'b0,3'd2,8'hC4, 2'b01,2'b00,8'h20}, // R8 drop
      '{1'b1,3'd5,8'hB5, 1'b1,3'd2,8'hC5, 2'b11,2'b00,8'h24}, // R5 other half granted
      '{1'b0,3'd5,8'hB6, 1'b1,3'd2,8'hC6, 2'b10,2'b00,8'h04}, // R10 release
      '{1'b1,3'd1,8'hA7, 1'b1,3'd2,8'hC7, 2'b10,2'b01,8'h04}, // R7 held src1 wins
      '{1'b0,3'd1,8'hA8, 1'b0,3'd2,8'hC8, 2'b00,2'b00,8'h00}, // R11 all idle
      '{1'b1,3'd3,8'h11, 1'b1,3'd0,8'h22, 2'b01,2'b10,8'h08}, // R6 tie, src0 wins
      '{1'b0,3'd3,8'h12, 1'b0,3'd0,8'h23, 2'b00,2'b00,8'h00}, // R10
      '{1'b1,3'd7,8'h33, 1'b1,3'd0,8'h44, 2'b11,2'b00,8'h81}, // R6 different halves
      '{1'b0,3'd0,8'h00, 1'b0,3'd0,8'h00, 2'b00,2'b00,8'h00}  // R11
   };

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp_v);
      end
   endtask

   task automatic drive(input logic r0, input logic [2:0] d0, input logic [7:0] x0,
                        input logic r1, input logic [2:0] d1, input logic [7:0] x1);
      src_req  = {r1, r0};
      src_dst  = {d1, d0};
      src_data = {x1, x0};
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [63:0] port_data(input logic [1:0] g, input logic [2:0] o0,
                                             input logic [2:0] o1);
      logic [63:0] v = '0;
      if (g[0]) v[o0*8 +: 8] = src_data[7:0];
      if (g[1]) v[o1*8 +: 8] = src_data[15:8];
      return v;
   endfunction

   initial begin : watchdog
      #800000;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [1:0] prev_g;
      logic [2:0] own0, own1;
      prev_g = '0; own0 = '0; own1 = '0;

      // R1: outputs during reset
      repeat (3) @(negedge clk);
      chk(src_gnt == 0 && src_blk == 0, "R1 gnt/blk in reset", {src_gnt, src_blk}, 0);
      chk(dst_vld == 0 && dst_data == 0, "R1 ports in reset", dst_data | 64'(dst_vld), 0);
      rst_n = 1'b1;
      step();
      chk(dst_vld == 0 && dst_data == 0, "R11 idle after reset", dst_data | 64'(dst_vld), 0);

      foreach (TBL[s]) begin
         drive(TBL[s].r0, TBL[s].d0, TBL[s].x0, TBL[s].r1, TBL[s].d1, TBL[s].x1);
         step();
         if (TBL[s].eg[0] && !prev_g[0]) own0 = TBL[s].d0;
         if (TBL[s].eg[1] && !prev_g[1]) own1 = TBL[s].d1;
         prev_g = TBL[s].eg;
         chk(src_gnt == TBL[s].eg, $sformatf("R3 R5 R6 gnt step %0d", s), 64'(src_gnt), 64'(TBL[s].eg));
         chk(src_blk == TBL[s].eb, $sformatf("R8 blk step %0d", s), 64'(src_blk), 64'(TBL[s].eb));
         chk(dst_vld == TBL[s].ev, $sformatf("R2 vld step %0d", s), 64'(dst_vld), 64'(TBL[s].ev));
         chk(dst_data == port_data(TBL[s].eg, own0, own1), $sformatf("R9 R11 data step %0d", s),
             dst_data, port_data(TBL[s].eg, own0, own1));
      end

      // R4: each source alone to each destination; R3: no grant before the edge
      for (int s = 0; s < 2; s++) begin
         for (int d = 0; d < ND; d++) begin
            logic [7:0] x;
            x = 8'(8'h40 + s*16 + d);
            if (s == 0) drive(1'b1, 3'(d), x, 1'b0, 3'd0, 8'h00);
            else        drive(1'b0, 3'd0, 8'h00, 1'b1, 3'(d), x);
            #1;
            chk(src_gnt == 0, "R3 grant not before edge", 64'(src_gnt), 0);
            @(negedge clk);
            chk(src_gnt == 2'(1 << s), "R4 grant", 64'(src_gnt), 64'(1 << s));
            chk(dst_vld == 8'(1 << d), "R4 port valid", 64'(dst_vld), 64'(1 << d));
            chk(dst_data[d*8 +: 8] == x, "R4 port data", 64'(dst_data[d*8 +: 8]), 64'(x));
            drive(1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00);
            step();
            chk(src_gnt == 0 && dst_vld == 0, "R10 released", {src_gnt, dst_vld}, 0);
         end
      end

      // R10: release and same-half request in one cycle -> still blocked
      drive(1'b1, 3'd1, 8'h5A, 1'b0, 3'd0, 8'h00);
      step();
      drive(1'b0, 3'd1, 8'h5A, 1'b1, 3'd3, 8'h6B);
      step();
      chk(src_gnt == 2'b00, "R10 gnt after release cycle", 64'(src_gnt), 0);
      chk(src_blk == 2'b10, "R10 blocked in release cycle", 64'(src_blk), 64'(2'b10));
      step();
      chk(src_blk == 2'b00 && src_gnt == 2'b00, "R8 pulse one cycle, held req no grant",
          {src_blk, src_gnt}, 0);
      drive(1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00);
      step();

      // R1: reset while a path is held
      drive(1'b1, 3'd4, 8'h77, 1'b0, 3'd0, 8'h00);
      step();
      chk(src_gnt == 2'b01 && dst_vld == 8'h10, "R2 before reset", {src_gnt, dst_vld}, {2'b01, 8'h10});
      rst_n = 1'b0;
      @(negedge clk);
      chk(src_gnt == 0 && dst_vld == 0 && dst_data == 0, "R1 reset clears path",
          dst_data | 64'(dst_vld) | 64'(src_gnt), 0);
      drive(1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00);
      rst_n = 1'b1;
      step();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule